// File: doc/BRIEF.md
# Bit-Serial Weighted Squared-Distance Accumulator

This block forms the exponent of a Gaussian potential for one or more stored prototypes. For every prototype it computes the weighted squared distance S = Σ k_n·(x_n − µ_n)² over N_LANES features. The whole computation runs on single-bit streams. Each feature enters as a two's complement word, least significant bit first, on one wire per lane. A full-adder cell with a carry flip-flop adds that stream to the negated centre. The negated centre sits in a shift register that rotates once per evaluation and ends up back in its starting position.

Each lane keeps the difference as it arrives and takes its magnitude once the sign bit is known. The lane then squares the magnitude with a serial-by-parallel multiplier and scales the result by the lane weight k_n with a second one. The square and scale bits are gated by mask signals from a shared controller. A binary tree of registered serial adders sums the lane streams. The controller drops the DROP_LSB lowest digits of the sum. The remaining bits leave LSB first on one wire per prototype, with a valid flag and a last-bit flag, ready to feed a bit-serial exponential unit.

All prototypes share the feature wires and the controller, and they run in lockstep. Centres are loaded in parallel while the block is idle. Weights are parallel constants that must be held stable during an evaluation.

Top module: `sqdist_serial`

## Requirements
- R1: While reset is low, and in the cycle after reset is released, dist_valid, dist_last and every dist_bit are 0.
- R2: For each prototype p, the OW = 2·(W+1)+KW+clog2(N_LANES)−DROP_LSB bits that stream out while dist_valid is high equal floor(Σ k_n·(x_n−µ_n)² / 2^DROP_LSB). Bit i of that value appears in the i-th valid cycle (LSB first). x_n, µ_n are W-bit two's complement and k_n is KW-bit unsigned.
- R3: Call the cycle in which start is sampled high while idle cycle 0. Feature bit i (LSB = bit 0) is taken in cycle i+1. The first valid output bit appears in cycle W+LG+DROP_LSB+2, where LG = clog2(N_LANES).
- R4: dist_valid stays high for exactly OW contiguous cycles. dist_last is high only in the final valid cycle. dist_bit is 0 whenever dist_valid is low.
- R5: Negative differences (x_n < µ_n) give the same result as the positive difference of equal size.
- R6: A centre register is back in its loaded state after each evaluation, so later evaluations without a reload use the same centres.
- R7: A start pulse during an evaluation, other than in its last output cycle, is ignored. The running result, its timing and its length are unchanged, and no second result follows.
- R8: A centre load request while an evaluation runs is ignored. The next evaluation still uses the previously loaded centres.
- R9: Extreme operands (x = −2^(W−1) against µ = 2^(W−1)−1 and the reverse, with k = 2^KW−1) produce the exact result without overflow. A lane with k = 0, or a prototype whose centres all equal x, contributes 0.
- R10: A start in the last output cycle of an evaluation is accepted and begins the next evaluation with no idle cycle. That evaluation follows the same timing as R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins an evaluation when idle or in the last output cycle |
| x_bit | input | N_LANES | One serial feature bit per lane, LSB first, bit i in cycle i+1 |
| cfg_load | input | 1 | Loads all centres from cfg_mu; ignored while busy |
| cfg_mu | input | N_PROTO·N_LANES·W | Centres, prototype p lane n at bits (p·N_LANES+n)·W upward |
| cfg_k | input | N_PROTO·N_LANES·KW | Weights, same packing with KW bits per field; held stable |
| dist_bit | output | N_PROTO | One serial result bit per prototype, LSB first |
| dist_valid | output | 1 | Result bits are valid in this cycle |
| dist_last | output | 1 | This is the final result bit |

## Verification
The first result bit is due W+LG+DROP_LSB+2 cycles after the start cycle: W+1 capture cycles, LG tree register stages and the dropped digits. With the defaults this is cycle 14. The last bit is due OW−1 cycles later, cycle 35 by default. The bench counts falling edges from the cycle in which it raises start. It drives the feature bits and samples the outputs at those falling edges, so each bit is read in the cycle it is due. The bench compares the position of the first and last valid cycles against these formulas. It also accepts a new start in the last output cycle and checks that the next evaluation keeps the same offsets.

// File: rtl/sqdist_pkg.sv
// Shared types and bit-level helpers for the serial squared-distance block.
// Assumes nothing beyond single-bit operands.
package sqdist_pkg;

    // Controller phase: idle, serial capture of the difference, serial multiply/sum.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CAP  = 2'd1,
        PH_MUL  = 2'd2
    } phase_t;

    // Sum output of a one-bit full adder.
    function automatic logic fa_sum(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    // Carry output of a one-bit full adder (majority).
    function automatic logic fa_carry(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/sqdist_ctrl.sv
// Central sequencer. It accepts start when idle or in the final output cycle.
// It then runs DW capture cycles and SW+LG multiply/sum cycles. It produces
// the lane enables, the square/scale mask signals and the output valid/last
// flags, including the suppression of the DROP_LSB lowest result digits.
// Assumes SW+LG > DW and that all lanes and trees follow it in lockstep.
module sqdist_ctrl
    import sqdist_pkg::*;
#(
    parameter int W        = 8,
    parameter int DW       = 9,
    parameter int SW       = 24,
    parameter int LG       = 2,
    parameter int DROP_LSB = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic cap_en,
    output logic cap_ext,
    output logic cap_last,
    output logic mul_en,
    output logic sq_mask,
    output logic sc_mask,
    output logic out_valid,
    output logic out_last
);
    localparam int MUL_LEN = SW + LG;
    localparam int CW      = $clog2(MUL_LEN + 1);
    localparam logic [CW-1:0] C_CAP_END = CW'(DW - 1);
    localparam logic [CW-1:0] C_EXT     = CW'(W);
    localparam logic [CW-1:0] C_SQ      = CW'(DW);
    localparam logic [CW-1:0] C_SC      = CW'(2 * DW);
    localparam logic [CW-1:0] C_OUT0    = CW'(LG + DROP_LSB);
    localparam logic [CW-1:0] C_MUL_END = CW'(MUL_LEN - 1);

    phase_t        ph_q;
    logic [CW-1:0] cnt_q;
    logic          fin;

    // Final cycle of the multiply/sum phase.
    assign fin    = (ph_q == PH_MUL) && (cnt_q == C_MUL_END);
    // Start is taken only when idle or in the final output cycle.
    assign accept = start && ((ph_q == PH_IDLE) || fin);

    // Phase and cycle counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else if (accept) begin
            ph_q  <= PH_CAP;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_CAP: begin
                    if (cnt_q == C_CAP_END) begin
                        ph_q  <= PH_MUL;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_MUL: begin
                    if (fin) begin
                        ph_q  <= PH_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    ph_q  <= PH_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // Decode lane strobes, masks and output flags from the phase and count.
    always_comb begin
        busy      = (ph_q != PH_IDLE);
        cap_en    = (ph_q == PH_CAP);
        cap_ext   = cap_en && (cnt_q >= C_EXT);
        cap_last  = cap_en && (cnt_q == C_CAP_END);
        mul_en    = (ph_q == PH_MUL);
        sq_mask   = mul_en && (cnt_q < C_SQ);
        sc_mask   = mul_en && (cnt_q < C_SC);
        out_valid = mul_en && (cnt_q >= C_OUT0);
        out_last  = fin;
    end

endmodule

// File: rtl/sqdist_lane.sv
// One feature lane. In capture it adds the serial feature bits (sign-extended
// to DW bits) to the rotating negated centre with a one-bit adder and carry
// flip-flop. It collects the difference and latches its magnitude once the
// sign bit is known. In the multiply phase it squares the magnitude serially
// and scales the square bits by k, both LSB first with one product bit per
// cycle. Assumes k is stable for the whole evaluation.
module sqdist_lane
    import sqdist_pkg::*;
#(
    parameter int W  = 8,
    parameter int DW = 9,
    parameter int KW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  mu,
    input  logic [KW-1:0] k,
    input  logic          x_bit,
    input  logic          clr,
    input  logic          cap_en,
    input  logic          cap_ext,
    input  logic          cap_last,
    input  logic          mul_en,
    input  logic          sq_mask,
    input  logic          sc_mask,
    output logic          prod_bit
);
    logic [DW-1:0] nm_q;
    logic          cy_q;
    logic [DW-1:0] d_q;
    logic          xh_q;
    logic [DW-1:0] mag_q;
    logic [DW-1:0] ms_q;
    logic [DW-1:0] asq_q;
    logic [KW-1:0] asc_q;

    logic          xb;
    logic          s_bit;
    logic          c_bit;
    logic [DW-1:0] d_nx;
    logic [DW-1:0] mag_nx;
    logic          sq_in;
    logic [DW:0]   tsq;
    logic          sc_in;
    logic [KW:0]   tsc;

    // Serial difference bit, completed difference and its magnitude.
    always_comb begin
        xb     = cap_ext ? xh_q : x_bit;
        s_bit  = fa_sum(xb, nm_q[0], cy_q);
        c_bit  = fa_carry(xb, nm_q[0], cy_q);
        d_nx   = {s_bit, d_q[DW-1:1]};
        mag_nx = d_nx[DW-1] ? (~d_nx + DW'(1)) : d_nx;
    end

    // Serial-by-parallel square and scale steps for the current cycle.
    always_comb begin
        sq_in    = ms_q[0] & sq_mask;
        tsq      = {1'b0, asq_q} + (sq_in ? {1'b0, mag_q} : '0);
        sc_in    = tsq[0] & sc_mask;
        tsc      = {1'b0, asc_q} + (sc_in ? {1'b0, k} : '0);
        prod_bit = mul_en & tsc[0];
    end

    // Centre storage, serial subtraction carry and difference collection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nm_q <= '0;
            cy_q <= 1'b0;
            d_q  <= '0;
            xh_q <= 1'b0;
        end else if (load) begin
            nm_q <= ~{mu[W-1], mu} + DW'(1);
        end else if (clr) begin
            cy_q <= 1'b0;
        end else if (cap_en) begin
            cy_q <= c_bit;
            nm_q <= {nm_q[0], nm_q[DW-1:1]};
            d_q  <= d_nx;
            xh_q <= xb;
        end
    end

    // Magnitude latch and multiplier accumulators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q <= '0;
            ms_q  <= '0;
            asq_q <= '0;
            asc_q <= '0;
        end else if (cap_last) begin
            mag_q <= mag_nx;
            ms_q  <= mag_nx;
            asq_q <= '0;
            asc_q <= '0;
        end else if (mul_en) begin
            ms_q  <= ms_q >> 1;
            asq_q <= tsq[DW:1];
            asc_q <= tsc[KW:1];
        end
    end

endmodule

// File: rtl/sqdist_tree.sv
// Binary tree of serial adders over N lane streams, padded with zero leaves
// to a power of two. Every node is a full adder with a carry flip-flop and a
// registered sum, so the root lags the leaves by LG cycles. Carries and sums
// clear on clr. Assumes LG = clog2(N).
module sqdist_tree
    import sqdist_pkg::*;
#(
    parameter int N  = 4,
    parameter int LG = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [N-1:0] leaf,
    output logic         root
);
    localparam int LEAVES = 1 << LG;

    logic [2*LEAVES-1:1] nb;

    genvar gi;
    generate
        for (gi = 0; gi < LEAVES; gi++) begin : g_leaf
            if (gi < N) begin : g_real
                assign nb[LEAVES+gi] = leaf[gi];
            end else begin : g_pad
                assign nb[LEAVES+gi] = 1'b0;
            end
        end
        for (gi = 1; gi < LEAVES; gi++) begin : g_node
            logic q_q;
            logic c_q;
            // One registered serial adder node.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    q_q <= 1'b0;
                    c_q <= 1'b0;
                end else if (en) begin
                    q_q <= fa_sum(nb[2*gi], nb[2*gi+1], c_q);
                    c_q <= fa_carry(nb[2*gi], nb[2*gi+1], c_q);
                end
            end
            assign nb[gi] = q_q;
        end
    endgenerate

    assign root = nb[1];

endmodule

// File: rtl/sqdist_serial.sv
// Top of the bit-serial weighted squared-distance accumulator. N_PROTO
// prototypes share the serial feature wires and one controller. Each has
// N_LANES lanes and an adder tree, and emits its result LSB first with the
// DROP_LSB lowest digits removed. Assumes the centres are loaded while idle
// and the weights are held stable during an evaluation.
module sqdist_serial
    import sqdist_pkg::*;
#(
    parameter int N_LANES  = 4,
    parameter int N_PROTO  = 2,
    parameter int W        = 8,
    parameter int KW       = 4,
    parameter int DROP_LSB = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [N_LANES-1:0]            x_bit,
    input  logic                          cfg_load,
    input  logic [N_PROTO*N_LANES*W-1:0]  cfg_mu,
    input  logic [N_PROTO*N_LANES*KW-1:0] cfg_k,
    output logic [N_PROTO-1:0]            dist_bit,
    output logic                          dist_valid,
    output logic                          dist_last
);
    localparam int DW = W + 1;
    localparam int LG = $clog2(N_LANES);
    localparam int PW = 2 * DW + KW;
    localparam int SW = PW + LG;
    localparam int OW = SW - DROP_LSB;

    logic start_ok, busy, cap_en, cap_ext, cap_last;
    logic mul_en, sq_mask, sc_mask, out_valid, out_last;
    logic load_ok;
    logic [N_PROTO-1:0] root;

    sqdist_ctrl #(
        .W(W), .DW(DW), .SW(SW), .LG(LG), .DROP_LSB(DROP_LSB)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .accept(start_ok), .busy(busy),
        .cap_en(cap_en), .cap_ext(cap_ext), .cap_last(cap_last),
        .mul_en(mul_en), .sq_mask(sq_mask), .sc_mask(sc_mask),
        .out_valid(out_valid), .out_last(out_last)
    );

    assign load_ok = cfg_load & ~busy;

    genvar gp, gn;
    generate
        for (gp = 0; gp < N_PROTO; gp++) begin : g_proto
            logic [N_LANES-1:0] prod;
            for (gn = 0; gn < N_LANES; gn++) begin : g_lane
                sqdist_lane #(.W(W), .DW(DW), .KW(KW)) u_lane (
                    .clk(clk), .rst_n(rst_n), .load(load_ok),
                    .mu(cfg_mu[(gp*N_LANES+gn)*W +: W]),
                    .k(cfg_k[(gp*N_LANES+gn)*KW +: KW]),
                    .x_bit(x_bit[gn]), .clr(start_ok),
                    .cap_en(cap_en), .cap_ext(cap_ext), .cap_last(cap_last),
                    .mul_en(mul_en), .sq_mask(sq_mask), .sc_mask(sc_mask),
                    .prod_bit(prod[gn])
                );
            end
            sqdist_tree #(.N(N_LANES), .LG(LG)) u_tree (
                .clk(clk), .rst_n(rst_n), .clr(start_ok), .en(mul_en),
                .leaf(prod), .root(root[gp])
            );
        end
    endgenerate

    // Output gating: result bits only during the valid window.
    always_comb begin
        dist_bit   = root & {N_PROTO{out_valid}};
        dist_valid = out_valid;
        dist_last  = out_last;
    end

endmodule

// File: rtl/sqdist_serial_chk.sv
// Property checker for sqdist_serial, bound to every instance of it. It
// watches the output stream framing and its timing relative to the accepted
// start. Assumes FIRST and OW match the top's derived sizes.
module sqdist_serial_chk #(
    parameter int N_PROTO = 2,
    parameter int OW      = 22,
    parameter int FIRST   = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               accept,
    input logic [N_PROTO-1:0] dist_bit,
    input logic               dist_valid,
    input logic               dist_last
);
    int vcnt_q;
    int since_q;

    // Count valid bits in the current evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) vcnt_q <= 0;
        else if (dist_valid)  vcnt_q <= vcnt_q + 1;
    end

    // Cycles since the accepted start (start cycle = 0).
    always_ff @(posedge clk) begin
        if (!rst_n)              since_q <= 0;
        else if (accept)         since_q <= 1;
        else if (since_q < 1000) since_q <= since_q + 1;
    end

    p_quiet_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dist_valid |-> (dist_bit == '0));
    p_last_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dist_last |-> dist_valid);
    p_contiguous_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dist_valid && !dist_last) |=> dist_valid);
    p_window_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dist_last |=> !dist_valid);
    p_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dist_last |-> (vcnt_q == OW - 1));
    p_first_bit_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dist_valid) |-> (since_q == FIRST));
    p_no_early_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !dist_valid);

endmodule

bind sqdist_serial sqdist_serial_chk #(
    .N_PROTO(N_PROTO), .OW(OW), .FIRST(W + LG + DROP_LSB + 2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .accept(start_ok),
    .dist_bit(dist_bit), .dist_valid(dist_valid), .dist_last(dist_last)
);

// File: tb/sqdist_serial_test.sv
`timescale 1ns/1ps
// Directed bench for sqdist_serial: one task per scenario, each checking itself.
module sqdist_serial_test;
    localparam int NL    = 4;
    localparam int NP    = 2;
    localparam int W     = 8;
    localparam int KW    = 4;
    localparam int DROP  = 2;
    localparam int DW    = W + 1;
    localparam int LG    = $clog2(NL);
    localparam int OW    = 2 * DW + KW + LG - DROP;
    localparam int FIRST = W + LG + DROP + 2;
    localparam int LASTC = FIRST + OW - 1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic [NL-1:0]          x_bit = '0;
    logic                   cfg_load = 1'b0;
    logic [NP*NL*W-1:0]     cfg_mu = '0;
    logic [NP*NL*KW-1:0]    cfg_k = '0;
    logic [NP-1:0]          dist_bit;
    logic                   dist_valid;
    logic                   dist_last;

    always #2 clk = ~clk;

    sqdist_serial #(.N_LANES(NL), .N_PROTO(NP), .W(W), .KW(KW), .DROP_LSB(DROP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .x_bit(x_bit),
        .cfg_load(cfg_load), .cfg_mu(cfg_mu), .cfg_k(cfg_k),
        .dist_bit(dist_bit), .dist_valid(dist_valid), .dist_last(dist_last)
    );

    int     total = 0;
    int     bad = 0;
    int     mu_t [NP][NL];
    int     k_t  [NP][NL];
    int     xv   [NL];
    longint got  [NP];
    int     first_c, last_c, nvalid;
    int     cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint expv(input int p);
        longint s = 0;
        for (int n = 0; n < NL; n++) begin
            longint d = longint'(xv[n]) - longint'(mu_t[p][n]);
            s += longint'(k_t[p][n]) * d * d;
        end
        return s >>> DROP;
    endfunction

    task automatic load_cfg();
        for (int p = 0; p < NP; p++)
            for (int n = 0; n < NL; n++) begin
                cfg_mu[(p*NL+n)*W +: W]   = W'(mu_t[p][n]);
                cfg_k[(p*NL+n)*KW +: KW]  = KW'(k_t[p][n]);
            end
        @(negedge clk); cfg_load = 1'b1;
        @(negedge clk); cfg_load = 1'b0;
    endtask

    // Drive one evaluation and collect the streams; cycle 0 = start cycle.
    task automatic run_eval(input bit wait_first, input bit extra_start, input bit extra_load);
        logic [NP*NL*W-1:0] saved_mu;
        saved_mu = cfg_mu;
        for (int p = 0; p < NP; p++) got[p] = 0;
        first_c = -1; last_c = -1; nvalid = 0;
        if (wait_first) @(negedge clk);
        start = 1'b1; x_bit = '0;
        for (int kc = 1; kc <= 60; kc++) begin
            @(negedge clk);
            if (dist_valid) begin
                if (first_c < 0) first_c = kc;
                for (int p = 0; p < NP; p++)
                    if (nvalid < 63) got[p] |= (longint'(dist_bit[p]) << nvalid);
                nvalid++;
            end
            if (dist_last) begin
                last_c = kc;
                start = 1'b0;
                break;
            end
            start = extra_start && (kc == 6);
            if (extra_load && kc == 6) begin
                cfg_mu = ~saved_mu; cfg_load = 1'b1;
            end else if (extra_load && kc == 7) begin
                cfg_mu = saved_mu; cfg_load = 1'b0;
            end
            for (int n = 0; n < NL; n++)
                x_bit[n] = (kc - 1 < W) ? 1'(xv[n] >>> (kc - 1)) : 1'b0;
        end
    endtask

    task automatic check_run(input string req);
        for (int p = 0; p < NP; p++) chk(got[p] == expv(p), req, got[p], expv(p));
        chk(first_c == FIRST, "R3 first bit cycle", first_c, FIRST);
        chk(last_c == LASTC, "R4 last bit cycle", last_c, LASTC);
        chk(nvalid == OW, "R4 valid bit count", nvalid, OW);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({dist_valid, dist_last, dist_bit} == '0, "R1 in reset", {dist_valid, dist_last, dist_bit}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({dist_valid, dist_last, dist_bit} == '0, "R1 after reset", {dist_valid, dist_last, dist_bit}, 0);
    endtask

    task automatic t_basic();
        int mv [NL] = '{12, -37, 90, -5};
        int kv [NL] = '{3, 7, 1, 15};
        for (int n = 0; n < NL; n++) begin
            mu_t[0][n] = mv[n];      k_t[0][n] = kv[n];
            mu_t[1][n] = -mv[n] / 2; k_t[1][n] = 16 - kv[n];
        end
        load_cfg();
        xv = '{40, 20, 100, 60};
        run_eval(1'b1, 1'b0, 1'b0);
        check_run("R2 basic");
    endtask

    task automatic t_negative();
        for (int n = 0; n < NL; n++) begin
            mu_t[0][n] = 60 + n; mu_t[1][n] = 110 - n;
        end
        load_cfg();
        xv = '{-70, -1, 5, -128};
        run_eval(1'b1, 1'b0, 1'b0);
        check_run("R5 negative differences");
    endtask

    task automatic t_recirc();
        xv = '{127, 0, -64, 33};
        run_eval(1'b1, 1'b0, 1'b0);
        check_run("R6 centres reused without reload");
    endtask

    task automatic t_start_ignored();
        xv = '{-20, 77, 3, -99};
        run_eval(1'b1, 1'b1, 1'b0);
        check_run("R7 start during run ignored");
        repeat (8) @(negedge clk);
        chk(dist_valid == 1'b0, "R7 no second result", dist_valid, 0);
    endtask

    task automatic t_load_ignored();
        xv = '{9, -9, 50, -50};
        run_eval(1'b1, 1'b0, 1'b1);
        check_run("R8 run with load request");
        xv = '{-3, 100, -128, 1};
        run_eval(1'b1, 1'b0, 1'b0);
        check_run("R8 old centres kept");
    endtask

    task automatic t_extremes();
        mu_t[0] = '{127, -128, 127, 0};  k_t[0] = '{15, 15, 0, 15};
        mu_t[1] = '{-128, 127, -5, 66};  k_t[1] = '{15, 15, 15, 15};
        load_cfg();
        xv = '{-128, 127, -128, 0};
        run_eval(1'b1, 1'b0, 1'b0);
        check_run("R9 extreme operands");
        mu_t[1] = '{-128, 127, -128, 0};
        load_cfg();
        run_eval(1'b1, 1'b0, 1'b0);
        chk(got[1] == 0, "R9 zero distance", got[1], 0);
        check_run("R9 zero distance and k=0 lane");
    endtask

    task automatic t_back2back();
        xv = '{1, 2, 3, 4};
        run_eval(1'b1, 1'b0, 1'b0);
        check_run("R10 first of pair");
        xv = '{-100, 50, -25, 125};
        run_eval(1'b0, 1'b0, 1'b0);
        check_run("R10 start in last cycle accepted");
    endtask

    task automatic t_random();
        for (int r = 0; r < 6; r++) begin
            for (int p = 0; p < NP; p++)
                for (int n = 0; n < NL; n++) begin
                    mu_t[p][n] = int'($urandom_range(255)) - 128;
                    k_t[p][n]  = int'($urandom_range(15));
                end
            load_cfg();
            for (int n = 0; n < NL; n++) xv[n] = int'($urandom_range(255)) - 128;
            run_eval(1'b1, 1'b0, 1'b0);
            check_run("R2 random");
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: got %0d cycles expected below 100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_negative();
        t_recirc();
        t_start_ignored();
        t_load_ignored();
        t_extremes();
        t_back2back();
        t_random();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule